// File: doc/BRIEF.md
# Serial-Control Enable and Format Selector

This block decides how a device is configured after reset. Until told otherwise it assumes the device is set up by its strapping pins. It then runs a long power-up timer that counts master-clock cycles and ends by raising a done flag. Software that wants serial control writes an enable bit through the serial port. The rising edge of that bit stops the power-up timer if it is still running. It also emits a one-cycle pulse that returns every control register to its default, and it marks the control port as active. From then on the shared pins belong to the serial port alone.

The block also picks the serial format. Two-wire (I2C) is the default. A pin serves as an address strap in two-wire mode and as chip select in SPI mode. That pin is resynchronised into the clock domain. The first falling edge seen on it after reset release switches the format to SPI, and SPI stays selected until the next reset. An enable that comes after the timer has already finished is still honoured, but the block raises a late-enable flag, because the strapped setup has already been applied by then.

Top module: `ctlport_mode_ctrl`

## Requirements
- R1: For as long as reset is held, and on release, the outputs read: format 0 (two-wire; 1 means SPI), control-active 0, default-load 0, done 0 and late 0.
- R2: With no enable, the done flag rises exactly SA_CYCLES+2 clock edges after `rst_n` is released. Two of these edges are for reset synchronisation. The done flag then stays high.
- R3: One edge after `ctl_en_i` is first sampled high, `dflt_load_o` goes high for exactly one cycle.
- R4: `ctl_active_o` rises on the same edge as the default-load pulse. It stays high until reset, even if `ctl_en_i` falls again.
- R5: If the enable rises before the timer completes, the done flag never rises. This holds even when the enable is sampled on the very edge that would have completed the count. In that case the late flag also stays low.
- R6: If the enable rises after done, done stays high and `late_en_o` rises on the same edge as the load pulse.
- R7: If `cs_pin_i` falls and stays low across the next rising clock edges, `fmt_spi_o` becomes 1 on the third edge after the fall, and not on the second.
- R8: Once SPI is selected, later edges on `cs_pin_i` and the enable do not change it back. Only reset returns the format to 0.
- R9: A low pulse on `cs_pin_i` that lies entirely between two rising clock edges is ignored. A pin held low from reset onward never selects SPI.
- R10: While `ctl_en_i` stays high, no further load pulse is issued. A new rising edge after a fall issues one more pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_pin_i | input | 1 | Shared address-strap / chip-select pin, asynchronous |
| ctl_en_i | input | 1 | Control-enable register bit from the serial port logic |
| fmt_spi_o | output | 1 | Format select: 0 two-wire, 1 SPI |
| ctl_active_o | output | 1 | Control port owns the shared pins |
| dflt_load_o | output | 1 | One-cycle pulse: load register defaults |
| sa_done_o | output | 1 | Strapped power-up sequence finished |
| late_en_o | output | 1 | Enable arrived after the strapped sequence finished |

## Verification
A counter that is off by even one count moves the rising edge of the done flag. A checker therefore sees the error the cycle the count ends, which is SA_CYCLES+2 edges after release. A broken edge detector on the enable shows up one edge after the enable rises, as a load pulse that is missing, too wide or repeated. A bad synchroniser or edge detector on the pin shows up three edges after the pin moves, as a format bit that flips too early, never flips, or falls back. A timer that ignores the enable is only exposed at the end of the full count, when done rises although it should have stayed low.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  typedef enum logic {
    FMT_TWO_WIRE = 1'b0,
    FMT_SPI      = 1'b1
  } port_fmt_e;
endpackage

// File: rtl/cpm_rst_sync.sv
module cpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cpm_pin_edge.sv
module cpm_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb sync_d[i] = pin_i;
      end else begin : g_next
        always_comb sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  // R7: a detected fall is a single-cycle event
  p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cpm_sa_timer.sv
module cpm_sa_timer #(
  parameter int SA_CYCLES = 262144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (SA_CYCLES > 2) ? $clog2(SA_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SA_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          step;

  always_comb begin
    step   = run_i & ~done_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (step) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R2: counter never passes its terminal value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R2: done is sticky
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  // R5: a stopped timer holds its count
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/ctlport_mode_ctrl.sv
module ctlport_mode_ctrl
  import ctlport_pkg::*;
#(
  parameter int SA_CYCLES   = 262144,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin_i,
  input  logic ctl_en_i,
  output logic fmt_spi_o,
  output logic ctl_active_o,
  output logic dflt_load_o,
  output logic sa_done_o,
  output logic late_en_o
);
  logic rst_q_n;
  logic pin_fall;
  logic sa_done;
  logic sa_run;
  logic en_rise;

  port_fmt_e fmt_q, fmt_d;
  logic en_prev_q, active_q, active_d, load_q, load_d, late_q, late_d;

  cpm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  cpm_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .pin_i  (cs_pin_i),
    .fall_o (pin_fall)
  );

  assign en_rise = ctl_en_i & ~en_prev_q;
  assign sa_run  = ~active_q & ~en_rise;

  cpm_sa_timer #(.SA_CYCLES(SA_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .run_i  (sa_run),
    .done_o (sa_done)
  );

  always_comb begin
    fmt_d    = pin_fall ? FMT_SPI : fmt_q;
    active_d = active_q | en_rise;
    load_d   = en_rise;
    late_d   = late_q | (en_rise & sa_done);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fmt_q     <= FMT_TWO_WIRE;
      en_prev_q <= 1'b0;
      active_q  <= 1'b0;
      load_q    <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      fmt_q     <= fmt_d;
      en_prev_q <= ctl_en_i;
      active_q  <= active_d;
      load_q    <= load_d;
      late_q    <= late_d;
    end
  end

  assign fmt_spi_o    = (fmt_q == FMT_SPI);
  assign ctl_active_o = active_q;
  assign dflt_load_o  = load_q;
  assign sa_done_o    = sa_done;
  assign late_en_o    = late_q;

  // R3: default-load pulse lasts one cycle
  p_load_width_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    dflt_load_o |=> !dflt_load_o);
  // R4: control-active is sticky
  p_active_sticky_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_active_o |=> ctl_active_o);
  // R4: every load pulse leaves the port active
  p_load_active_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    dflt_load_o |-> ctl_active_o);
  // R5: done never rises once the control port owns the pins
  p_no_done_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sa_done_o) |-> !ctl_active_o);
  // R6: late flag only ever follows completion
  p_late_done_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(late_en_o) |-> (sa_done_o && dflt_load_o));
  // R8: SPI selection is sticky
  p_spi_sticky_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    fmt_spi_o |=> fmt_spi_o);
endmodule

// File: tb/ctlport_mode_ctrl_bench.sv
module ctlport_mode_ctrl_bench;
  localparam int SA = 40;

  logic clk = 1'b0;
  logic rst_n, cs_pin, ctl_en;
  logic fmt_spi, ctl_active, dflt_load, sa_done, late_en;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 0;

  always #2.5 clk = ~clk;

  ctlport_mode_ctrl #(.SA_CYCLES(SA)) u_ctlport_mode_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_pin_i     (cs_pin),
    .ctl_en_i     (ctl_en),
    .fmt_spi_o    (fmt_spi),
    .ctl_active_o (ctl_active),
    .dflt_load_o  (dflt_load),
    .sa_done_o    (sa_done),
    .late_en_o    (late_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n  = 1'b0;
    cs_pin = pin;
    ctl_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    chk("R1 fmt", fmt_spi, 1'b0);
    chk("R1 active", ctl_active, 1'b0);
    chk("R1 load", dflt_load, 1'b0);
    chk("R1 done", sa_done, 1'b0);
    chk("R1 late", late_en, 1'b0);
  endtask

  task automatic t_timer_done;
    do_reset(1'b1);
    tick(SA + 1);
    chk("R2 done early", sa_done, 1'b0);
    tick(1);
    chk("R2 done on time", sa_done, 1'b1);
    tick(5);
    chk("R2 done held", sa_done, 1'b1);
    chk("R2 late idle", late_en, 1'b0);
  endtask

  task automatic t_enable_mid;
    do_reset(1'b1);
    tick(10);
    ctl_en = 1'b1;
    tick(1);
    chk("R3 pulse", dflt_load, 1'b1);
    chk("R4 active", ctl_active, 1'b1);
    tick(1);
    chk("R3 pulse width", dflt_load, 1'b0);
    tick(4);
    chk("R10 no repeat", dflt_load, 1'b0);
    tick(SA);
    chk("R5 done blocked", sa_done, 1'b0);
    ctl_en = 1'b0;
    tick(2);
    chk("R4 active held", ctl_active, 1'b1);
    ctl_en = 1'b1;
    tick(1);
    chk("R10 second pulse", dflt_load, 1'b1);
    tick(1);
    chk("R10 second width", dflt_load, 1'b0);
  endtask

  task automatic t_enable_boundary;
    do_reset(1'b1);
    tick(SA + 1);
    ctl_en = 1'b1;
    tick(1);
    chk("R5 boundary done", sa_done, 1'b0);
    chk("R5 boundary pulse", dflt_load, 1'b1);
    tick(10);
    chk("R5 boundary done later", sa_done, 1'b0);
    chk("R5 boundary late", late_en, 1'b0);
  endtask

  task automatic t_enable_late;
    do_reset(1'b1);
    tick(SA + 4);
    chk("R2 done before late", sa_done, 1'b1);
    ctl_en = 1'b1;
    tick(1);
    chk("R6 late", late_en, 1'b1);
    chk("R6 done kept", sa_done, 1'b1);
    chk("R6 pulse", dflt_load, 1'b1);
  endtask

  task automatic t_spi_select;
    do_reset(1'b1);
    tick(5);
    cs_pin = 1'b0;
    tick(2);
    chk("R7 not yet", fmt_spi, 1'b0);
    tick(1);
    chk("R7 spi", fmt_spi, 1'b1);
    cs_pin = 1'b1;
    tick(3);
    cs_pin = 1'b0;
    tick(3);
    cs_pin = 1'b1;
    ctl_en = 1'b1;
    tick(5);
    chk("R8 sticky", fmt_spi, 1'b1);
    do_reset(1'b1);
    tick(2);
    chk("R8 reset clears", fmt_spi, 1'b0);
  endtask

  task automatic t_pin_glitch;
    do_reset(1'b1);
    tick(5);
    cs_pin = 1'b0;
    #1 cs_pin = 1'b1;
    tick(6);
    chk("R9 glitch", fmt_spi, 1'b0);
    do_reset(1'b0);
    tick(10);
    chk("R9 tied low", fmt_spi, 1'b0);
  endtask

  initial begin
    rst_n  = 1'b0;
    cs_pin = 1'b1;
    ctl_en = 1'b0;
    t_reset_state;
    t_timer_done;
    t_enable_mid;
    t_enable_boundary;
    t_enable_late;
    t_spi_select;
    t_pin_glitch;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule